// File: doc/BRIEF.md
# Unaligned Word Access Controller

This controller connects a byte-addressed 32-bit request port to a memory that is organised as 32-bit words. The memory has one word index, four byte-lane enables and a read path with a fixed latency. A byte, halfword or word access that fits inside one memory word is served by a single memory request. For a write, only the lanes that are covered are enabled.

A read that crosses a word boundary, or that begins at an odd byte for a halfword, does not raise a fault. The controller fetches the containing word and then the next word, and merges the requested bytes into one result. When the second word would lie past the top of the address space, its index wraps to zero and nothing is flagged. A write that is not naturally aligned is rejected with a one-cycle error pulse and does not touch memory.

The requester presents a read or write strobe while ready is high. It then waits for the done or error pulse. Requests that arrive while the controller is busy are ignored.

Top module: `ua_ctrl`

## Requirements
- R1: The memory word index is the request byte address with its two low bits dropped. An aligned access issues exactly one memory request, at that index.
- R2: Size codes are 0 for byte, 1 for halfword, 2 for word, and 3, which behaves as a word. Write data is right-justified on the request side. Enable bit i gates memory data bits [8i+7:8i], which hold the byte at word offset 3-i. A byte write at offset k enables only bit 3-k. A halfword write enables 1100 at offset 0 and 0011 at offset 2. A word write enables 1111. Bytes that are not enabled keep their value.
- R3: Memory is big-endian: the lowest byte address goes to the most significant position. Byte reads return the byte in bits [7:0], zero-extended. Halfword reads return two bytes in bits [15:0], zero-extended.
- R4: A word read at an offset other than 0 reads word index n and then n+1, and returns the four bytes that start at the request address. With bytes 0x01 to 0x08 at addresses 0 to 7, a read at address 1 returns 0x02030405.
- R5: A halfword read with address bit 0 set (offset 1 or 3) is split in the same two-read way. At offset 3 it returns the last byte of word n followed by the first byte of word n+1.
- R6: When the second read of a split would pass the top word, its index wraps to 0. No error is raised.
- R7: A word write at a nonzero offset, or a halfword write with address bit 0 set, produces one error pulse. It produces no memory write and no done pulse.
- R8: The accepting edge counts as edge 0. Done is high for one cycle after edge 1 for a write, after edge 1+RD_LAT for an aligned read, and after edge 2+2*RD_LAT for a split read. Error is high in the cycle after edge 0. The read result is valid while done is high.
- R9: Ready is high only when the controller is idle. Strobes seen while ready is low have no effect. Ready returns on the edge after done or error. If both strobes are high, the request is taken as a write.
- R10: Offset, index, size and write data are captured at acceptance. Changes to the request inputs during a transaction do not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd_i | input | 1 | Read strobe |
| req_wr_i | input | 1 | Write strobe |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | 32 | Right-justified write data |
| req_rdy_o | output | 1 | Idle, accepting a request |
| req_done_o | output | 1 | One-cycle completion pulse |
| req_err_o | output | 1 | One-cycle misaligned-write pulse |
| req_rdata_o | output | 32 | Read result |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Memory access is a write |
| mem_widx_o | output | ADDR_W-2 | Word index |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-steered write data |
| mem_rdata_i | input | 32 | Read data, RD_LAT cycles after the request |

## Verification
The bench builds the controller with ADDR_W = 6 and RD_LAT = 2, which gives a 16-word space. With this size, word 15 and the wrap to word 0 are reached by ordinary requests, so split reads at byte addresses 61 to 63 exercise the wrap. A read latency of two keeps the wait counter from collapsing to a single cycle. It also separates the two memory requests of a split read by several idle cycles, so the done timing of aligned and split reads differs clearly.

// File: rtl/ua_pkg.sv
// Shared types for the unaligned word access controller.
// Assumes a 32-bit data path made of four byte lanes.
package ua_pkg;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE,
        ST_ERR
    } state_e;

    // True when an access of this size at this offset is not naturally aligned
    function automatic logic misaligned(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return off[0];
            default: return off != 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/ua_lane_ctl.sv
// Write lane steering: turns size, offset and right-justified data into
// byte enables and lane-replicated write data.
// Assumes the access is aligned (misaligned writes never reach memory).
// Lane i carries the byte at word offset 3-i.
module ua_lane_ctl
    import ua_pkg::*;
(
    input  logic [1:0]    size_i,
    input  logic [1:0]    off_i,
    input  logic [DW-1:0] wdata_i,
    output logic [NB-1:0] be_o,
    output logic [DW-1:0] lane_data_o
);
    // Select enables and replicate data per access size
    always_comb begin
        case (size_i)
            SZ_BYTE: begin
                be_o        = 4'b1000 >> off_i;
                lane_data_o = {4{wdata_i[7:0]}};
            end
            SZ_HALF: begin
                be_o        = off_i[1] ? 4'b0011 : 4'b1100;
                lane_data_o = {2{wdata_i[15:0]}};
            end
            default: begin
                be_o        = 4'b1111;
                lane_data_o = wdata_i;
            end
        endcase
    end
endmodule

// File: rtl/ua_merge.sv
// Read merge: takes a 64-bit window (first word high, second word low),
// shifts it left by the byte offset and right-justifies the requested bytes.
// Assumes big-endian byte order within each word.
module ua_merge
    import ua_pkg::*;
(
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    input  logic [1:0]    off_i,
    input  logic [1:0]    size_i,
    output logic [DW-1:0] res_o
);
    logic [2*DW-1:0] win;
    logic [DW-1:0]   top;

    // Align the first requested byte to the top of the window
    always_comb begin
        win = {hi_i, lo_i} << {off_i, 3'b000};
        top = win[2*DW-1:DW];
    end

    // Right-justify and zero-extend by size
    always_comb begin
        case (size_i)
            SZ_BYTE: res_o = {24'h0, top[31:24]};
            SZ_HALF: res_o = {16'h0, top[31:16]};
            default: res_o = top;
        endcase
    end
endmodule

// File: rtl/ua_ctrl.sv
// Unaligned word access controller (top).
// Serves aligned accesses with one memory request and splits misaligned
// word/halfword reads into two consecutive word reads, which are merged.
// Misaligned writes are rejected with an error pulse.
// Assumes memory read data arrives exactly RD_LAT cycles after the request
// cycle (RD_LAT >= 1) and that writes take effect at the request edge.
module ua_ctrl
    import ua_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic [31:0]       req_wdata_i,
    output logic              req_rdy_o,
    output logic              req_done_o,
    output logic              req_err_o,
    output logic [31:0]       req_rdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-3:0] mem_widx_o,
    output logic [3:0]        mem_be_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

    state_e           st;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       off_q;
    logic [1:0]       size_q;
    logic             we_q;
    logic             phase_q;
    logic             split_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    w0_q;
    logic [DW-1:0]    rdata_q;
    logic [DW-1:0]    merged;
    logic [DW-1:0]    m_hi;
    logic [DW-1:0]    m_lo;
    logic             accept;
    logic             misal_in;

    // Request acceptance and alignment classification of the incoming request
    always_comb begin
        accept   = (st == ST_IDLE) && (req_rd_i || req_wr_i);
        misal_in = misaligned(req_size_i, req_addr_i[1:0]);
    end

    // Sequencer: capture, issue, wait for read data, merge, complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            idx_q   <= '0;
            off_q   <= '0;
            size_q  <= '0;
            we_q    <= 1'b0;
            phase_q <= 1'b0;
            split_q <= 1'b0;
            cnt_q   <= '0;
            wdata_q <= '0;
            w0_q    <= '0;
            rdata_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    idx_q   <= req_addr_i[ADDR_W-1:2];
                    off_q   <= req_addr_i[1:0];
                    size_q  <= req_size_i;
                    we_q    <= req_wr_i;
                    wdata_q <= req_wdata_i;
                    phase_q <= 1'b0;
                    split_q <= misal_in && !req_wr_i;
                    st      <= (req_wr_i && misal_in) ? ST_ERR : ST_REQ;
                end
                ST_REQ: begin
                    cnt_q <= CNT_W'(RD_LAT - 1);
                    st    <= we_q ? ST_DONE : ST_WAIT;
                end
                ST_WAIT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (split_q && !phase_q) begin
                        w0_q    <= mem_rdata_i;
                        phase_q <= 1'b1;
                        st      <= ST_REQ;
                    end else begin
                        rdata_q <= merged;
                        st      <= ST_DONE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Merge window: second phase combines held first word with incoming word
    always_comb begin
        m_hi = phase_q ? w0_q : mem_rdata_i;
        m_lo = phase_q ? mem_rdata_i : '0;
    end

    ua_merge u_merge (
        .hi_i   (m_hi),
        .lo_i   (m_lo),
        .off_i  (off_q),
        .size_i (size_q),
        .res_o  (merged)
    );

    ua_lane_ctl u_lane (
        .size_i      (size_q),
        .off_i       (off_q),
        .wdata_i     (wdata_q),
        .be_o        (mem_be_o),
        .lane_data_o (mem_wdata_o)
    );

    // Port decode from sequencer state; second index wraps in IDX_W bits
    always_comb begin
        req_rdy_o   = (st == ST_IDLE);
        req_done_o  = (st == ST_DONE);
        req_err_o   = (st == ST_ERR);
        req_rdata_o = rdata_q;
        mem_req_o   = (st == ST_REQ);
        mem_we_o    = (st == ST_REQ) && we_q;
        mem_widx_o  = idx_q + IDX_W'(phase_q);
    end
endmodule

// File: rtl/ua_ctrl_chk.sv
// Protocol checker for ua_ctrl, attached by bind.
// Tracks the last read index within a transaction to check split ordering.
module ua_ctrl_chk #(
    parameter int IDX_W = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_rd_i,
    input logic             req_wr_i,
    input logic             req_rdy_o,
    input logic             req_done_o,
    input logic             req_err_o,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [IDX_W-1:0] mem_widx_o,
    input logic [3:0]       mem_be_o
);
    logic [IDX_W-1:0] last_idx;
    logic             seen_rd;
    logic [IDX_W-1:0] next_idx;

    // Remember the first read index of the current transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rd  <= 1'b0;
            last_idx <= '0;
        end else if (req_rdy_o) begin
            seen_rd <= 1'b0;
        end else if (mem_req_o && !mem_we_o) begin
            seen_rd  <= 1'b1;
            last_idx <= mem_widx_o;
        end
    end

    // Expected index of a follow-on read, wrapping at the top
    always_comb next_idx = last_idx + 1'b1;

    p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !req_rdy_o);

    p_accept_drops_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rdy_o && (req_rd_i || req_wr_i)) |=> !req_rdy_o);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_done_o |=> (!req_done_o && req_rdy_o));

    p_err_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_err_o |-> (!req_done_o && !mem_req_o && $past(req_rdy_o)));

    p_we_with_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_req_o);

    p_be_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_be_o == 4'b1111 || mem_be_o == 4'b1100 ||
                      mem_be_o == 4'b0011 || $countones(mem_be_o) == 1));

    // Second read of a split goes to the next index, wrapping (R4, R6)
    p_split_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && seen_rd) |-> (mem_widx_o == next_idx));
endmodule

bind ua_ctrl ua_ctrl_chk #(.IDX_W(IDX_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_rd_i   (req_rd_i),
    .req_wr_i   (req_wr_i),
    .req_rdy_o  (req_rdy_o),
    .req_done_o (req_done_o),
    .req_err_o  (req_err_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_widx_o (mem_widx_o),
    .mem_be_o   (mem_be_o)
);

// File: tb/test_ua_ctrl.sv
// Bench: byte-level reference model with per-cycle handshake comparison.
module test_ua_ctrl;
    localparam int AW     = 6;
    localparam int LAT    = 2;
    localparam int IW     = AW - 2;
    localparam int NBYTES = 1 << AW;
    localparam int NWORDS = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    size = '0;
    logic [31:0]   wdata = '0;
    logic          rdy, done, err, mreq, mwe;
    logic [31:0]   rdata, mwdata, mrdata;
    logic [IW-1:0] midx;
    logic [3:0]    mbe;

    always #4 clk = ~clk;

    ua_ctrl #(.ADDR_W(AW), .RD_LAT(LAT)) i_ua_ctrl (
        .clk(clk), .rst_n(rst_n), .req_rd_i(rd), .req_wr_i(wr),
        .req_addr_i(addr), .req_size_i(size), .req_wdata_i(wdata),
        .req_rdy_o(rdy), .req_done_o(done), .req_err_o(err), .req_rdata_o(rdata),
        .mem_req_o(mreq), .mem_we_o(mwe), .mem_widx_o(midx), .mem_be_o(mbe),
        .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
    );

    // Word memory with fixed read latency; initial pattern loaded in reset
    logic [31:0]   mem_w [NWORDS];
    logic [IW-1:0] pipe  [LAT];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NBYTES; a++) mem_w[a/4][8*(3-a%4) +: 8] <= 8'(a + 1);
        end else if (mreq && mwe) begin
            for (int i = 0; i < 4; i++) if (mbe[i]) mem_w[midx][8*i +: 8] <= mwdata[8*i +: 8];
        end
        pipe[0] <= midx;
        for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
    end
    assign mrdata = mem_w[pipe[LAT-1]];

    // Reference model state
    logic [7:0]  ref_b [NBYTES];
    int          left = 0;
    bit          exp_err = 0, exp_rd = 0;
    logic [31:0] exp_data = '0;
    string       exp_tag = "R1";
    int          n_cmp = 0, n_bad = 0, cyc = 0;
    bit          ended = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Behavioural model: accept when idle, predict result and completion time
    always @(posedge clk) begin
        if (!rst_n) begin
            left = 0;
            for (int a = 0; a < NBYTES; a++) ref_b[a] = 8'(a + 1);
        end else if (left > 0) begin
            left--;
        end else if (rd || wr) begin
            int a, n, lat;
            bit mis;
            logic [31:0] d;
            a   = int'(addr);
            n   = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
            mis = (size == 2'd0) ? 1'b0 : (size == 2'd1) ? addr[0] : (addr[1:0] != 2'd0);
            if (wr) begin
                exp_rd = 0;
                exp_err = mis;
                lat = mis ? 0 : 1;
                if (!mis)
                    for (int k = 0; k < n; k++) ref_b[(a + k) % NBYTES] = 8'(wdata >> (8 * (n - 1 - k)));
            end else begin
                exp_rd = 1;
                exp_err = 0;
                d = '0;
                for (int k = 0; k < n; k++) d = (d << 8) | 32'(ref_b[(a + k) % NBYTES]);
                exp_data = d;
                lat = mis ? 2 + 2 * LAT : 1 + LAT;
            end
            left = lat + 1;
        end
    end

    // Per-cycle comparison away from the active edge (R8, R9)
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk("R9 ready", 32'(rdy), 32'(left == 0));
            chk("R8 done", 32'(done), 32'(left == 1 && !exp_err));
            chk("R7 err", 32'(err), 32'(left == 1 && exp_err));
            if (left == 1 && exp_rd && !exp_err) chk(exp_tag, rdata, exp_data);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !ended) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected completion");
            finish_run();
        end
    end

    // One request; hold keeps strobes up while busy, scr changes inputs after accept
    task automatic req(input bit r, input bit w, input int a, input int sz,
                       input logic [31:0] wd, input string tag, input int hold, input bit scr);
        @(negedge clk);
        exp_tag = tag;
        rd = r; wr = w; addr = AW'(a); size = 2'(sz); wdata = wd;
        @(negedge clk);
        if (scr) begin
            addr = addr ^ AW'(6'h2B); size = ~size; wdata = ~wdata;
        end
        repeat (hold) @(negedge clk);
        rd = 0; wr = 0;
        while (left != 0) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // Reset state (R9)
        chk("R9 reset ready", 32'(rdy), 32'd1);
        chk("R8 reset done", 32'(done), 32'd0);
        chk("R7 reset err", 32'(err), 32'd0);
        chk("R1 reset memreq", 32'(mreq), 32'd0);
        rst_n = 1;
        // Aligned word reads (R1)
        req(1, 0, 0, 2, 0, "R1 word@0", 0, 0);
        req(1, 0, 60, 2, 0, "R1 word@60", 0, 0);
        // Split word reads (R4)
        req(1, 0, 1, 2, 0, "R4 word@1", 0, 0);
        req(1, 0, 2, 2, 0, "R4 word@2", 0, 0);
        req(1, 0, 7, 2, 0, "R4 word@7", 0, 0);
        // Byte and aligned halfword reads (R3)
        for (int o = 0; o < 4; o++) req(1, 0, 20 + o, 0, 0, "R3 byte", 0, 0);
        req(1, 0, 24, 1, 0, "R3 half@24", 0, 0);
        req(1, 0, 26, 1, 0, "R3 half@26", 0, 0);
        // Misaligned halfword reads (R5)
        req(1, 0, 25, 1, 0, "R5 half@25", 0, 0);
        req(1, 0, 27, 1, 0, "R5 half@27", 0, 0);
        // Wrap past the top word (R6)
        req(1, 0, 61, 2, 0, "R6 word@61", 0, 0);
        req(1, 0, 63, 2, 0, "R6 word@63", 0, 0);
        req(1, 0, 63, 1, 0, "R6 half@63", 0, 0);
        // Writes with lane enables, then read-back (R2)
        req(0, 1, 5, 0, 32'hFFFF_FFAA, "R2 wr byte", 0, 0);
        req(0, 1, 6, 1, 32'hFFFF_BEEF, "R2 wr half", 0, 0);
        req(0, 1, 8, 2, 32'h1122_3344, "R2 wr word", 0, 0);
        req(0, 1, 12, 3, 32'hA5B6_C7D8, "R2 wr size3", 0, 0);
        req(1, 0, 4, 2, 0, "R2 readback@4", 0, 0);
        req(1, 0, 8, 3, 0, "R2 readback@8", 0, 0);
        req(1, 0, 5, 2, 0, "R2 split readback@5", 0, 0);
        req(1, 0, 12, 2, 0, "R2 readback@12", 0, 0);
        // Misaligned writes rejected, memory untouched (R7)
        req(0, 1, 9, 2, 32'hDEAD_BEEF, "R7 wr word@9", 0, 0);
        req(0, 1, 13, 1, 32'h0000_7777, "R7 wr half@13", 0, 0);
        req(1, 0, 8, 2, 0, "R7 check@8", 0, 0);
        req(1, 0, 12, 2, 0, "R7 check@12", 0, 0);
        // Byte write at the top, then wrapping read over it (R6)
        req(0, 1, 63, 0, 32'h0000_00C3, "R6 wr byte@63", 0, 0);
        req(1, 0, 62, 2, 0, "R6 word@62", 0, 0);
        // Inputs changed and strobes held while busy (R10, R9)
        req(1, 0, 3, 2, 0, "R10 scrambled split", 2, 1);
        req(1, 0, 16, 0, 0, "R10 scrambled byte", 2, 1);
        req(0, 1, 28, 2, 32'h0BAD_F00D, "R10 scrambled write", 0, 1);
        req(1, 0, 28, 2, 0, "R10 readback@28", 0, 0);
        // Both strobes: write wins (R9)
        req(1, 1, 32, 0, 32'h0000_005A, "R9 both strobes", 0, 0);
        req(1, 0, 32, 2, 0, "R9 readback@32", 0, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule